// File: doc/BRIEF.md
# Microcoded Single-Bus Accumulator Processor

This block is a small accumulator machine in which every machine instruction runs as a fixed sequence of microinstructions. A microcode ROM, indexed by a 4-bit micro-address, drives read strobes and write strobes onto one shared data bus. Each instruction takes a set number of cycles that depends only on its opcode and, for the zero-test jump, on the accumulator. The registers are a memory address register, a program counter, an accumulator, an instruction register, an ALU operand latch and an ALU result latch. A word-addressed memory of 2^ADDR_W words sits inside the block. It is written by the store micro-step or by the preload port.

Words are ADDR_W+3 bits wide. The opcode occupies bits [ADDR_W+2:ADDR_W] and the operand address occupies bits [ADDR_W-1:0]. The surrounding logic fills the memory through the preload port while reset is held. It then releases reset and watches the micro-address, program counter and accumulator. The micro-address reads 0 at each instruction boundary. A combinational debug read port returns any memory word. All pins are plain control or data pins: there is no streaming interface, so no back-pressure rules apply.

Top module: `mac_cpu`

## Requirements
- R1: While reset is low, and on the first sample after it is released, the micro-address, program counter and accumulator read 0, so the first instruction comes from word 0.
- R2: Fetch takes three micro-steps: step 0 loads the address register from the PC, step 1 loads the instruction register from memory, and step 2 loads the address register from the instruction register and moves to micro-address opcode+3, where the opcode is word bits [ADDR_W+2:ADDR_W].
- R3: Cycles per instruction, counted from one micro-address 0 to the next, are: opcode 0 with ACC zero 5, opcode 0 with ACC nonzero 6, opcode 1 4, opcodes 2 and 3 8, opcodes 4, 5 and 6 6, opcode 7 5.
- R4: Opcode 2 sets ACC to (ACC + mem[a]) mod 2^(ADDR_W+3), with a = word bits [ADDR_W-1:0], and advances the PC by one.
- R5: Opcode 3 sets ACC to (ACC - mem[a]) mod 2^(ADDR_W+3) and advances the PC by one.
- R6: Opcode 4 loads ACC from mem[a]; opcode 5 writes ACC into mem[a] and leaves ACC unchanged; both advance the PC by one.
- R7: Opcode 1 copies the whole instruction word into the PC. Opcode 0 does the same when ACC is zero, and otherwise advances the PC by one. A taken jump does not add one to the PC.
- R8: Opcodes 6 and 7 leave ACC and memory unchanged and advance the PC by one.
- R9: The PC is ADDR_W+3 bits wide and wraps to 0 after its largest value. Memory is indexed by the low ADDR_W bits of the address register. The increment runs at micro-address 10, which computes PC+1 into the result latch, and micro-address 11, which writes that value to the PC and returns to micro-address 0.
- R10: At most one bus source drives in any cycle. The PC changes only at the micro-steps that write it (4 and 11), so it holds its value inside an instruction.
- R11: A cycle with ld_en high writes ld_data into word ld_addr. dbg_data always shows word dbg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | ADDR_W | Preload word address |
| ld_data | input | ADDR_W+3 | Preload word value |
| dbg_addr | input | ADDR_W | Debug read address |
| dbg_data | output | ADDR_W+3 | Memory word at dbg_addr |
| upc_o | output | 4 | Current micro-address |
| pc_o | output | ADDR_W+3 | Program counter |
| acc_o | output | ADDR_W+3 | Accumulator |

## Verification
The bench drives both outcomes of the zero-test jump. A wrong sense of the ACC test either skips the increment tail or enters it on a taken branch, and that shows up as a 5/6 cycle swap and a wrong PC. Add and subtract results that wrap past 2^(ADDR_W+3) catch an ALU that swaps its operands or keeps a carry bit. A run of plain instructions drives the PC past 127 and back to 0, which exposes a PC that is too narrow or a memory index that does not take the low bits. An unconditional jump whose word has high bits set catches a PC that keeps only the address field. The bench also checks the PC at every intermediate cycle, so an increment written early or twice shows up at once.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int UPC_W = 4;

  // mode bits: [1] forces a branch, [0] selects target field / zero test
  typedef enum logic [1:0] {
    SEQ_NEXT     = 2'b00,
    SEQ_IFNZ     = 2'b01,
    SEQ_DISPATCH = 2'b10,
    SEQ_GOTO     = 2'b11
  } seq_mode_e;

  typedef struct packed {
    logic      mem_wr;
    logic      mem_rd;
    logic      mar_wr;
    logic      pc_wr;
    logic      pc_rd;
    logic      acc_wr;
    logic      acc_rd;
    logic      ir_wr;
    logic      ir_rd;
    logic      arg_wr;
    logic      alu_f0;
    logic      alu_f1;
    logic      buf_rd;
    seq_mode_e mode;
    logic [UPC_W-1:0] target;
  } uword_t;

  function automatic uword_t urom(input logic [UPC_W-1:0] a);
    uword_t w;
    w = '0;
    w.mode = SEQ_GOTO;
    unique case (a)
      4'd0:  begin w.pc_rd  = 1'b1; w.mar_wr = 1'b1; w.mode = SEQ_NEXT; end
      4'd1:  begin w.mem_rd = 1'b1; w.ir_wr  = 1'b1; w.mode = SEQ_NEXT; end
      4'd2:  begin w.ir_rd  = 1'b1; w.mar_wr = 1'b1; w.mode = SEQ_DISPATCH; end
      4'd3:  begin w.mode = SEQ_IFNZ; w.target = 4'd10; end
      4'd4:  begin w.ir_rd  = 1'b1; w.pc_wr  = 1'b1; w.target = 4'd0; end
      4'd5:  begin w.acc_rd = 1'b1; w.arg_wr = 1'b1; w.target = 4'd12; end
      4'd6:  begin w.acc_rd = 1'b1; w.arg_wr = 1'b1; w.target = 4'd13; end
      4'd7:  begin w.mem_rd = 1'b1; w.acc_wr = 1'b1; w.target = 4'd10; end
      4'd8:  begin w.acc_rd = 1'b1; w.mem_wr = 1'b1; w.target = 4'd10; end
      4'd9:  begin w.mode = SEQ_NEXT; end
      4'd10: begin w.pc_rd  = 1'b1; w.alu_f1 = 1'b1; w.mode = SEQ_NEXT; end
      4'd11: begin w.buf_rd = 1'b1; w.pc_wr  = 1'b1; w.target = 4'd0; end
      4'd12: begin w.mem_rd = 1'b1; w.target = 4'd14; end
      4'd13: begin w.mem_rd = 1'b1; w.alu_f0 = 1'b1; w.mode = SEQ_NEXT; end
      4'd14: begin w.buf_rd = 1'b1; w.acc_wr = 1'b1; w.target = 4'd10; end
      default: begin w.target = 4'd0; end
    endcase
    return w;
  endfunction

endpackage

// File: rtl/mac_alu.sv
module mac_alu #(
  parameter int W = 7
) (
  input  logic         f0,
  input  logic         f1,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  always_comb begin
    unique case ({f0, f1})
      2'b00:   res = opa + opb;
      2'b10:   res = opa - opb;
      2'b01:   res = opb + W'(1);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/mac_useq.sv
module mac_useq
  import mac_pkg::*;
#(
  parameter int OPC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_mode_e        mode,
  input  logic [UPC_W-1:0] target,
  input  logic             acc_nz,
  input  logic [OPC_W-1:0] opcode,
  output logic [UPC_W-1:0] upc
);
  logic             force_br, zero_br, take_br;
  logic [UPC_W-1:0] br_base, base, step, nxt;

  assign force_br = mode[1];
  assign zero_br  = mode[0] & acc_nz;
  assign take_br  = force_br | zero_br;
  assign br_base  = mode[0] ? target : UPC_W'(opcode);
  assign base     = take_br ? br_base : upc;
  assign step     = take_br ? (mode[0] ? UPC_W'(0) : UPC_W'(3)) : UPC_W'(1);
  assign nxt      = base + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt;
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  uword_t            uw,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [ADDR_W+2:0] ld_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [ADDR_W+2:0] dbg_data,
  output logic [ADDR_W+2:0] pc_q,
  output logic [ADDR_W+2:0] acc_q,
  output logic [ADDR_W+2:0] ir_q,
  output logic [ADDR_W+2:0] buf_q,
  output logic              acc_nz,
  output logic [2:0]        opcode,
  output logic [4:0]        bus_src
);
  localparam int W     = ADDR_W + 3;
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] mar_q, arg_q, bus, mem_q, alu_y;

  assign mem_q    = mem[mar_q[ADDR_W-1:0]];
  assign dbg_data = mem[dbg_addr];
  assign bus_src  = {uw.mem_rd, uw.pc_rd, uw.acc_rd, uw.ir_rd, uw.buf_rd};

  always_comb begin
    if      (uw.mem_rd) bus = mem_q;
    else if (uw.pc_rd)  bus = pc_q;
    else if (uw.acc_rd) bus = acc_q;
    else if (uw.ir_rd)  bus = ir_q;
    else if (uw.buf_rd) bus = buf_q;
    else                bus = '0;
  end

  mac_alu #(.W(W)) u_alu (
    .f0  (uw.alu_f0),
    .f1  (uw.alu_f1),
    .opa (arg_q),
    .opb (bus),
    .res (alu_y)
  );

  always_ff @(posedge clk) begin
    if (ld_en)          mem[ld_addr] <= ld_data;
    else if (uw.mem_wr) mem[mar_q[ADDR_W-1:0]] <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      pc_q  <= '0;
      acc_q <= '0;
      ir_q  <= '0;
      arg_q <= '0;
      buf_q <= '0;
    end else begin
      if (uw.mar_wr) mar_q <= bus;
      if (uw.pc_wr)  pc_q  <= bus;
      if (uw.acc_wr) acc_q <= bus;
      if (uw.ir_wr)  ir_q  <= bus;
      if (uw.arg_wr) arg_q <= bus;
      buf_q <= alu_y;
    end
  end

  assign acc_nz = |acc_q;
  assign opcode = ir_q[ADDR_W +: 3];
endmodule

// File: rtl/mac_cpu.sv
module mac_cpu
  import mac_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [ADDR_W+2:0] ld_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [ADDR_W+2:0] dbg_data,
  output logic [UPC_W-1:0]  upc_o,
  output logic [ADDR_W+2:0] pc_o,
  output logic [ADDR_W+2:0] acc_o
);
  localparam int W = ADDR_W + 3;

  uword_t       uw;
  logic         acc_nz;
  logic [2:0]   opcode;
  logic [W-1:0] ir_q, buf_q;
  logic [4:0]   bus_src;

  assign uw = urom(upc_o);

  mac_useq #(.OPC_W(3)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (uw.mode),
    .target (uw.target),
    .acc_nz (acc_nz),
    .opcode (opcode),
    .upc    (upc_o)
  );

  mac_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .uw       (uw),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data),
    .pc_q     (pc_o),
    .acc_q    (acc_o),
    .ir_q     (ir_q),
    .buf_q    (buf_q),
    .acc_nz   (acc_nz),
    .opcode   (opcode),
    .bus_src  (bus_src)
  );
endmodule

// File: rtl/mac_cpu_chk.sv
module mac_cpu_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        upc,
  input logic [ADDR_W+2:0] pc,
  input logic [ADDR_W+2:0] acc,
  input logic [ADDR_W+2:0] ir,
  input logic [ADDR_W+2:0] buf_q,
  input logic [4:0]        bus_src
);
  localparam int W = ADDR_W + 3;

  a_r10_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_src));

  a_r2_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 4'd0 |=> upc == 4'd1);

  a_r2_fetch_second: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 4'd1 |=> upc == 4'd2);

  a_r2_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 4'd2 |=> upc == 4'({1'b0, $past(ir[ADDR_W +: 3])} + 4'd3));

  a_r9_inc_compute: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 4'd10 |=> (upc == 4'd11 && buf_q == W'($past(pc) + W'(1))));

  a_r9_inc_commit: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 4'd11 |=> (upc == 4'd0 && pc == $past(buf_q)));

  a_r7_jump_word: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 4'd4 |=> (upc == 4'd0 && pc == $past(ir)));

  a_r7_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
    upc == 4'd3 |=> upc == ((acc == '0) ? 4'd4 : 4'd10));

  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upc != 4'd4 && upc != 4'd11) |=> $stable(pc));
endmodule

bind mac_cpu mac_cpu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .upc     (upc_o),
  .pc      (pc_o),
  .acc     (acc_o),
  .ir      (ir_q),
  .buf_q   (buf_q),
  .bus_src (bus_src)
);

// File: tb/mac_cpu_test.sv
module mac_cpu_test;
  localparam int AW = 4;
  localparam int W  = AW + 3;
  localparam int DEPTH = 1 << AW;
  localparam int MODW  = 1 << W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [W-1:0]  ld_data = '0;
  logic [AW-1:0] dbg_addr = '0;
  logic [W-1:0]  dbg_data;
  logic [3:0]    upc_o;
  logic [W-1:0]  pc_o, acc_o;

  int total = 0;
  int bad = 0;
  int bm [DEPTH];
  bit aborted = 0;

  always #5 clk = ~clk;

  mac_cpu #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .upc_o(upc_o), .pc_o(pc_o), .acc_o(acc_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cyc_of(input int op, input int acc);
    case (op)
      0: return (acc == 0) ? 5 : 6;
      1: return 4;
      2, 3: return 8;
      7: return 5;
      default: return 6;
    endcase
  endfunction

  task automatic load_and_reset();
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = W'(bm[i]);
    end
    @(negedge clk);
    ld_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      dbg_addr = AW'(i);
      #1;
      chk("R11 preload", int'(dbg_data), bm[i]);
    end
    chk("R1 upc in reset", int'(upc_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 upc", int'(upc_o), 0);
    chk("R1 pc", int'(pc_o), 0);
    chk("R1 acc", int'(acc_o), 0);
  endtask

  task automatic run_insts(input int n);
    int mpc, macc;
    mpc = 0; macc = 0;
    for (int k = 0; k < n && !aborted; k++) begin
      int inst, op, a, ec, npc, nacc, cnt, start_pc;
      inst = bm[mpc % DEPTH];
      op   = inst >> AW;
      a    = inst % DEPTH;
      ec   = cyc_of(op, macc);
      npc  = (mpc + 1) % MODW;
      nacc = macc;
      case (op)
        0: if (macc == 0) npc = inst;
        1: npc = inst;
        2: nacc = (macc + bm[a]) % MODW;
        3: nacc = (macc - bm[a] + MODW) % MODW;
        4: nacc = bm[a];
        5: bm[a] = macc;
        default: ;
      endcase
      start_pc = int'(pc_o);
      chk("R9 pc at boundary", start_pc, mpc);
      cnt = 0;
      do begin
        @(posedge clk);
        @(negedge clk);
        cnt++;
        if (upc_o != 4'd0) chk("R10 pc held", int'(pc_o), start_pc);
      end while (upc_o != 4'd0 && cnt < 16);
      chk("R2 R3 cycles", cnt, ec);
      if (upc_o != 4'd0) begin
        aborted = 1;
      end
      case (op)
        0, 1: chk("R7 pc", int'(pc_o), npc);
        default: chk("R9 pc", int'(pc_o), npc);
      endcase
      case (op)
        2: chk("R4 acc", int'(acc_o), nacc);
        3: chk("R5 acc", int'(acc_o), nacc);
        4, 5: chk("R6 acc", int'(acc_o), nacc);
        6, 7: chk("R8 acc", int'(acc_o), nacc);
        default: chk("R7 acc", int'(acc_o), nacc);
      endcase
      dbg_addr = AW'(a);
      #1;
      if (op == 5) chk("R6 store", int'(dbg_data), bm[a]);
      else         chk("R8 mem untouched", int'(dbg_data), bm[a]);
      mpc = npc; macc = nacc;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // directed program: load zero, taken zero-jump, add with wrap,
    // subtract below zero, store, untaken zero-jump, no-ops, wide jump
    bm[0] = 'h4E; bm[1] = 'h05; bm[2] = 'h10; bm[3] = 'h70;
    bm[4] = 'h60; bm[5] = 'h2D; bm[6] = 'h2D; bm[7] = 'h3C;
    bm[8] = 'h5B; bm[9] = 'h00; bm[10] = 'h60; bm[11] = 'h13;
    bm[12] = 80;  bm[13] = 100; bm[14] = 0;    bm[15] = 'h7F;
    load_and_reset();
    run_insts(40);

    // PC wrap: every word a no-op, run past 2^W instructions
    for (int i = 0; i < DEPTH; i++) bm[i] = 'h7F;
    load_and_reset();
    run_insts(MODW + 4);

    // pseudo-random memory images
    for (int s = 1; s <= 6 && !aborted; s++) begin
      for (int i = 0; i < DEPTH; i++)
        bm[i] = (s * 53 + i * 29 + i * i * 11 + s * i * 7) % MODW;
      bm[DEPTH-1] = 0;
      load_and_reset();
      run_insts(120);
    end
    if (aborted) begin
      total++; bad++;
      $display("FAIL R3 actual=stuck expected=return to micro-address 0");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule